// File: doc/BRIEF.md
# Daisy-Chained Next-Free-Entry Locator

This block watches the occupancy bits of an associative memory, one bit per entry (1 = occupied, 0 = empty), and keeps a registered pointer to the lowest-numbered empty entry. Each clock edge captures the occupancy vector. If any entry is empty, the pointer takes the index of the lowest empty one. If every entry is occupied, the pointer keeps its previous value and the device counts as locally full.

Several devices can be chained to form one large memory. A device learns that every device ahead of it is full through an active-low full-in input. It passes the combined condition on through an active-low full-out output.

Two outputs gate the shared bus:

- A respond output enables the pointer onto the bus for a read-next-free request. In chain mode it is granted to the single device that is first in line with free space. In direct mode it goes to the locally selected device.
- A write-hit output tells the device to carry out a write aimed at the next-free location. Only the first device in line with free space executes such a write.

Top module: `nf_locator`

## Requirements
- R1: While rst_ni is low, nf_ptr_o is 0, full_no is 1, and both resp_o and wr_hit_o are 0 when no strobe is active.
- R2: After a rising clock edge at which valid_i had at least one 0 bit, nf_ptr_o equals the lowest bit index of valid_i that was 0 at that edge.
- R3: After a rising clock edge at which valid_i was all ones, nf_ptr_o keeps the value it had before that edge.
- R4: full_no is 0 exactly when full_ni is 0 and valid_i was all ones at the most recent rising edge. It changes with full_ni in the same cycle.
- R5: With chain_en_ni at 0 and rd_nf_i at 1, resp_o is 1 exactly when full_ni is 0 and the device is not locally full (the last captured valid_i had a 0 bit). dev_sel_i has no effect in this mode.
- R6: With chain_en_ni at 1 and rd_nf_i at 1, resp_o equals dev_sel_i, whether or not the device is full.
- R7: wr_hit_o is 1 exactly when wr_nf_i is 1, full_ni is 0 and the device is not locally full. chain_en_ni and dev_sel_i have no effect on it.
- R8: resp_o is 0 whenever rd_nf_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | N | Occupancy bit per entry, 1 = occupied |
| full_ni | input | 1 | Low when all upstream devices are full (tie low on the first device) |
| chain_en_ni | input | 1 | Low selects chain arbitration for next-free reads |
| dev_sel_i | input | 1 | This device is the addressed one |
| rd_nf_i | input | 1 | Read-next-free request |
| wr_nf_i | input | 1 | Write-to-next-free request |
| nf_ptr_o | output | $clog2(N) | Index of lowest empty entry |
| full_no | output | 1 | Low when this device and all upstream ones are full |
| resp_o | output | 1 | Drive-enable for the pointer on a read |
| wr_hit_o | output | 1 | This device executes the next-free write |

## Verification
A read request and a write request can arrive in the same cycle. That cycle can also be the first one after the device has captured an all-occupied vector, so the respond and write-hit decisions must use the newly registered full state while the pointer holds. The bench provokes this with random vectors that are often all ones or have a single free entry. Random strobes, full-in levels and chain modes are driven alongside. A behavioural model of the registered state judges resp_o, wr_hit_o, full_no and nf_ptr_o on every clock.

// File: rtl/nf_pkg.sv
package nf_pkg;
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_CHAIN  = 2'd1,
    SRC_SELECT = 2'd2
  } resp_src_e;
endpackage

// File: rtl/nf_first_free.sv
module nf_first_free #(
  parameter int N    = 64,
  parameter int IDXW = $clog2(N)
) (
  input  logic [N-1:0]    valid_i,
  output logic [IDXW-1:0] idx_o,
  output logic            any_free_o
);
  // scan from the top so the lowest empty index wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) idx_o = IDXW'(i);
    end
  end

  assign any_free_o = ~&valid_i;
endmodule

// File: rtl/nf_ptr_reg.sv
module nf_ptr_reg #(
  parameter int IDXW = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IDXW-1:0] idx_i,
  input  logic            any_free_i,
  output logic [IDXW-1:0] nf_q_o,
  output logic            full_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nf_q_o   <= '0;
      full_q_o <= 1'b0;
    end else begin
      full_q_o <= ~any_free_i;
      if (any_free_i) nf_q_o <= idx_i;
    end
  end
endmodule

// File: rtl/nf_chain_ctl.sv
module nf_chain_ctl
  import nf_pkg::*;
(
  input  logic      full_ni,
  input  logic      chain_en_ni,
  input  logic      dev_sel_i,
  input  logic      rd_nf_i,
  input  logic      wr_nf_i,
  input  logic      full_q_i,
  output logic      full_no,
  output resp_src_e resp_src_o,
  output logic      wr_hit_o
);
  logic first_free;

  // upstream all full, this one still has room
  assign first_free = ~full_ni & ~full_q_i;
  assign full_no    = ~(~full_ni & full_q_i);
  assign wr_hit_o   = wr_nf_i & first_free;

  always_comb begin
    resp_src_o = SRC_NONE;
    if (rd_nf_i) begin
      if (!chain_en_ni) begin
        if (first_free) resp_src_o = SRC_CHAIN;
      end else if (dev_sel_i) begin
        resp_src_o = SRC_SELECT;
      end
    end
  end
endmodule

// File: rtl/nf_locator.sv
module nf_locator
  import nf_pkg::*;
#(
  parameter int N    = 64,
  parameter int IDXW = $clog2(N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    valid_i,
  input  logic            full_ni,
  input  logic            chain_en_ni,
  input  logic            dev_sel_i,
  input  logic            rd_nf_i,
  input  logic            wr_nf_i,
  output logic [IDXW-1:0] nf_ptr_o,
  output logic            full_no,
  output logic            resp_o,
  output logic            wr_hit_o
);
  logic [IDXW-1:0] idx;
  logic            any_free;
  logic            full_q;
  resp_src_e       resp_src;

  nf_first_free #(.N(N), .IDXW(IDXW)) u_search (
    .valid_i   (valid_i),
    .idx_o     (idx),
    .any_free_o(any_free)
  );

  nf_ptr_reg #(.IDXW(IDXW)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_i     (idx),
    .any_free_i(any_free),
    .nf_q_o    (nf_ptr_o),
    .full_q_o  (full_q)
  );

  nf_chain_ctl u_ctl (
    .full_ni    (full_ni),
    .chain_en_ni(chain_en_ni),
    .dev_sel_i  (dev_sel_i),
    .rd_nf_i    (rd_nf_i),
    .wr_nf_i    (wr_nf_i),
    .full_q_i   (full_q),
    .full_no    (full_no),
    .resp_src_o (resp_src),
    .wr_hit_o   (wr_hit_o)
  );

  assign resp_o = (resp_src != SRC_NONE);
endmodule

// File: rtl/nf_locator_chk.sv
module nf_locator_chk #(
  parameter int N    = 64,
  parameter int IDXW = $clog2(N)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N-1:0]    valid_i,
  input logic            full_ni,
  input logic            chain_en_ni,
  input logic            dev_sel_i,
  input logic            rd_nf_i,
  input logic            wr_nf_i,
  input logic [IDXW-1:0] nf_ptr_o,
  input logic            full_no,
  input logic            resp_o,
  input logic            wr_hit_o
);
  logic [N-1:0] v_d;
  logic         was_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_d <= '0;
    else         v_d <= valid_i;
  end

  assign was_full = &v_d;

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (nf_ptr_o == '0) && full_no);

  // R2
  lowest_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !was_full |-> !v_d[nf_ptr_o]);

  // R3
  hold_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&valid_i) |=> $stable(nf_ptr_o));

  // R4
  full_chain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_no == !(!full_ni && was_full));

  // R5
  chain_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chain_en_ni && rd_nf_i) |-> (resp_o == (!full_ni && !was_full)));

  // R6
  select_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain_en_ni && rd_nf_i) |-> (resp_o == dev_sel_i));

  // R7
  write_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit_o == (wr_nf_i && !full_ni && !was_full));

  // R8
  no_read_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_nf_i |-> !resp_o);
endmodule

bind nf_locator nf_locator_chk #(.N(N), .IDXW(IDXW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .full_ni    (full_ni),
  .chain_en_ni(chain_en_ni),
  .dev_sel_i  (dev_sel_i),
  .rd_nf_i    (rd_nf_i),
  .wr_nf_i    (wr_nf_i),
  .nf_ptr_o   (nf_ptr_o),
  .full_no    (full_no),
  .resp_o     (resp_o),
  .wr_hit_o   (wr_hit_o)
);

// File: tb/nf_locator_tb.sv
`timescale 1ns/1ps
module nf_locator_tb;
  localparam int N    = 64;
  localparam int IDXW = $clog2(N);

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [N-1:0]    valid_i = '0;
  logic            full_ni = 1'b0;
  logic            chain_en_ni = 1'b0;
  logic            dev_sel_i = 1'b0;
  logic            rd_nf_i = 1'b0;
  logic            wr_nf_i = 1'b0;
  logic [IDXW-1:0] nf_ptr_o;
  logic            full_no;
  logic            resp_o;
  logic            wr_hit_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int ref_nf = 0;
  bit ref_full = 1'b0;
  bit held = 1'b0;

  always #10 clk = ~clk;

  nf_locator #(.N(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .full_ni(full_ni),
    .chain_en_ni(chain_en_ni), .dev_sel_i(dev_sel_i), .rd_nf_i(rd_nf_i),
    .wr_nf_i(wr_nf_i), .nf_ptr_o(nf_ptr_o), .full_no(full_no),
    .resp_o(resp_o), .wr_hit_o(wr_hit_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle(logic [N-1:0] v, bit fi, bit ce, bit ds, bit rd, bit wr);
    bit elig;
    int k;
    @(negedge clk);
    valid_i = v; full_ni = fi; chain_en_ni = ce; dev_sel_i = ds;
    rd_nf_i = rd; wr_nf_i = wr;
    #1;
    elig = !fi && !ref_full;
    chk(held ? "R3 nf_ptr" : "R2 nf_ptr", int'(nf_ptr_o), ref_nf);
    chk("R4 full_no", int'(full_no), int'(!(!fi && ref_full)));
    if (!rd)     chk("R8 resp", int'(resp_o), 0);
    else if (!ce) chk("R5 resp", int'(resp_o), int'(elig));
    else          chk("R6 resp", int'(resp_o), int'(ds));
    chk("R7 wr_hit", int'(wr_hit_o), int'(wr && elig));
    @(posedge clk);
    k = 0;
    while (k < N && v[k]) k++;
    held = (k == N);
    ref_full = held;
    if (!held) ref_nf = k;
  endtask

  function automatic logic [N-1:0] one_hole(int k);
    logic [N-1:0] v;
    v = '1;
    v[k] = 1'b0;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 nf_ptr", int'(nf_ptr_o), 0);
    chk("R1 full_no", int'(full_no), 1);
    chk("R1 resp", int'(resp_o), 0);
    chk("R1 wr_hit", int'(wr_hit_o), 0);
    rst_ni = 1'b1;

    cycle('0, 0, 0, 0, 1, 1);              // R2 empty memory -> 0
    cycle(one_hole(N-1), 0, 0, 0, 1, 0);   // R2 top entry
    cycle('1, 0, 0, 0, 1, 1);              // R3 now full
    cycle('1, 0, 0, 0, 1, 1);              // R4/R5/R7 full device silent
    cycle('1, 1, 0, 0, 1, 1);              // R4 upstream not full
    cycle('1, 0, 1, 1, 1, 0);              // R6 selected while full
    cycle(one_hole(31), 0, 1, 0, 1, 1);    // R6 unselected, R7 ignores select
    cycle(one_hole(0), 0, 0, 1, 1, 1);     // R5 chain
    cycle(one_hole(5), 1, 0, 1, 1, 1);     // R5 upstream has room
    cycle(one_hole(5), 0, 0, 0, 0, 0);     // R8

    for (int n = 0; n < 600; n++) begin
      int m;
      int k;
      m = $urandom % 4;
      k = $urandom % N;
      case (m)
        0: v = '1;
        1: v = one_hole(k);
        2: v = {$urandom, $urandom};
        default: begin
          v = '1;
          for (int i = k; i < N; i++) v[i] = 1'($urandom % 2);
          v[k] = 1'b0;
        end
      endcase
      cycle(v, 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
            1'($urandom % 2), 1'($urandom % 2));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule